// File: doc/BRIEF.md
# Product-Term AND Plane with Per-Row Disable

This block is the sum-of-products front end for a bank of eight output macrocells. It takes twenty input or feedback signals and presents each one on two array columns, one true and one inverted, for forty columns in total. Sixty-four product-term rows each form the AND of the columns that their connection bits select. The rows are grouped eight to a macrocell, and the macrocells choose from these rows for their OR and enable functions.

Each row also has a disable bit. When that bit is set, the row is held low whatever its connection bits say, so it can never take part in a downstream OR. The connection map and the disable vector are static configuration words. The plane has no clock and no state: every product term follows its inputs in the same evaluation, with no register between input and output.

Top module: `pla_and_plane`

## Requirements
- R1: Column 2k carries signal k (`sig_in[k]`) unchanged, and column 2k+1 carries its inverse, for k = 0..19.
- R2: Product term r (`term_out[r]`) is the AND of every column c for which connection bit `link_map[r*40 + c]` is 1. A bit value of 1 means the column is connected to the row.
- R3: When `term_kill[r]` is 1, `term_out[r]` is 0, whatever the connection bits and inputs are.
- R4: A row connected to both the true column and the inverted column of the same signal outputs 0.
- R5: A row with no connection bits set outputs 1, unless its disable bit is set.
- R6: Rows are independent of one another. Row r serves macrocell r/8 as its local term r%8. Changing one row's connections or disable bit leaves every other row's output unchanged.
- R7: The plane is purely combinational. An input change shows on `term_out` with zero clock cycles of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sig_in | input | 20 | Input and feedback signals that feed the column drivers |
| link_map | input | 2560 | Connection bits: row r uses bits r*40 through r*40+39, and bit c selects column c |
| term_kill | input | 64 | Disable bit for each row; 1 forces that row to 0 |
| term_out | output | 64 | Product-term values; bits 8m through 8m+7 belong to macrocell m |

## Verification
The assertions check three things in every evaluation of every row. A disabled row is low. A row connected to both polarities of one signal is low. An enabled row with no connections is high. The column drivers are also checked to keep each true and inverted pair opposite.

The AND function itself can only be shown by the bench's scenarios. These are: single-literal rows, rows connected to every true column or every inverted column with one input flipped, mixed-polarity rows, and a walk of every signal through both polarities. The bench also checks that the other 63 rows stay at their empty value while one row is being exercised, and that a disable pattern maps onto the right macrocell slots.

// File: rtl/pla_pkg.sv
package pla_pkg;
    // Array geometry shared by the plane and its bench.
    localparam int SIG_N          = 20;
    localparam int CELL_N         = 8;
    localparam int TERMS_PER_CELL = 8;
    localparam int COL_N          = 2 * SIG_N;
    localparam int ROW_N          = CELL_N * TERMS_PER_CELL;
    localparam int LINK_W         = ROW_N * COL_N;
endpackage

// File: rtl/pla_col_drive.sv
module pla_col_drive #(
    parameter int SIG_N = pla_pkg::SIG_N,
    localparam int COL_N = 2 * SIG_N
) (
    input  logic [SIG_N-1:0] sig_in,
    output logic [COL_N-1:0] col_out
);
    // Even column: true form. Odd column: inverted form.
    for (genvar k = 0; k < SIG_N; k++) begin : g_pair
        assign col_out[2*k]   = sig_in[k];
        assign col_out[2*k+1] = ~sig_in[k];
    end

    always_comb begin
        for (int k = 0; k < SIG_N; k++) begin
            AST_COL_PAIR_OPPOSITE: assert (col_out[2*k] != col_out[2*k+1]) else $error("column pair %0d not complementary", k); // R1
        end
    end
endmodule

// File: rtl/pla_term_row.sv
module pla_term_row #(
    parameter int COL_N = pla_pkg::COL_N
) (
    input  logic [COL_N-1:0] col_in,
    input  logic [COL_N-1:0] links,
    input  logic             kill,
    output logic             term
);
    logic and_hit;

    // An unconnected column acts as a 1 in the AND.
    assign and_hit = &(col_in | ~links);
    assign term    = and_hit & ~kill;

    logic pair_clash;
    always_comb begin
        pair_clash = 1'b0;
        for (int k = 0; k < COL_N / 2; k++) begin
            pair_clash = pair_clash | (links[2*k] & links[2*k+1]);
        end
    end

    always_comb begin
        if (kill) begin
            AST_KILLED_ROW_LOW: assert (term == 1'b0) else $error("disabled row is high"); // R3
        end
        if (pair_clash) begin
            AST_BOTH_POLARITIES_LOW: assert (term == 1'b0) else $error("row with both polarities is high"); // R4
        end
        if (links == '0 && !kill) begin
            AST_EMPTY_ROW_HIGH: assert (term == 1'b1) else $error("empty enabled row is low"); // R5
        end
    end
endmodule

// File: rtl/pla_cell_group.sv
module pla_cell_group #(
    parameter int COL_N = pla_pkg::COL_N,
    parameter int TERMS = pla_pkg::TERMS_PER_CELL,
    localparam int LW   = COL_N * TERMS
) (
    input  logic [COL_N-1:0] col_in,
    input  logic [LW-1:0]    links,
    input  logic [TERMS-1:0] kill,
    output logic [TERMS-1:0] terms
);
    for (genvar j = 0; j < TERMS; j++) begin : g_row
        pla_term_row #(.COL_N(COL_N)) i_row (
            .col_in (col_in),
            .links  (links[j*COL_N +: COL_N]),
            .kill   (kill[j]),
            .term   (terms[j])
        );
    end

    always_comb begin
        if (&kill) begin
            AST_GROUP_ALL_KILLED: assert (terms == '0) else $error("fully disabled group has a high term"); // R6
        end
    end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int SIG_N          = pla_pkg::SIG_N,
    parameter int CELL_N         = pla_pkg::CELL_N,
    parameter int TERMS_PER_CELL = pla_pkg::TERMS_PER_CELL,
    localparam int COL_N  = 2 * SIG_N,
    localparam int ROW_N  = CELL_N * TERMS_PER_CELL,
    localparam int LINK_W = ROW_N * COL_N,
    localparam int GRP_LW = TERMS_PER_CELL * COL_N
) (
    input  logic [SIG_N-1:0]  sig_in,
    input  logic [LINK_W-1:0] link_map,
    input  logic [ROW_N-1:0]  term_kill,
    output logic [ROW_N-1:0]  term_out
);
    logic [COL_N-1:0] cols;

    pla_col_drive #(.SIG_N(SIG_N)) i_cols (
        .sig_in  (sig_in),
        .col_out (cols)
    );

    for (genvar m = 0; m < CELL_N; m++) begin : g_cell
        pla_cell_group #(.COL_N(COL_N), .TERMS(TERMS_PER_CELL)) i_grp (
            .col_in (cols),
            .links  (link_map[m*GRP_LW +: GRP_LW]),
            .kill   (term_kill[m*TERMS_PER_CELL +: TERMS_PER_CELL]),
            .terms  (term_out[m*TERMS_PER_CELL +: TERMS_PER_CELL])
        );
    end

    always_comb begin
        AST_NO_HIGH_WHEN_KILLED: assert ((term_out & term_kill) == '0) else $error("high term on a disabled row"); // R3
    end
endmodule

// File: tb/test_pla_and_plane.sv
module test_pla_and_plane;
    import pla_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic [SIG_N-1:0]  sig_in;
    logic [LINK_W-1:0] link_map;
    logic [ROW_N-1:0]  term_kill;
    logic [ROW_N-1:0]  term_out;

    pla_and_plane i_pla_and_plane (
        .sig_in    (sig_in),
        .link_map  (link_map),
        .term_kill (term_kill),
        .term_out  (term_out)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct packed {
        logic [19:0] sig;
        logic [5:0]  row;
        logic [39:0] link;
        logic        kill;
        logic        exp;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{20'h00000, 6'd0,  40'h0000000002, 1'b0, 1'b1}, // R2 inverted sig0
        '{20'h00000, 6'd0,  40'h0000000001, 1'b0, 1'b0}, // R2 true sig0
        '{20'h00001, 6'd5,  40'h0000000001, 1'b0, 1'b1}, // R2
        '{20'h80000, 6'd63, 40'h4000000000, 1'b0, 1'b1}, // R2 true sig19
        '{20'h80000, 6'd63, 40'h8000000000, 1'b0, 1'b0}, // R2 inverted sig19
        '{20'hFFFFF, 6'd17, 40'h5555555555, 1'b0, 1'b1}, // R2 all true
        '{20'hFFFFE, 6'd17, 40'h5555555555, 1'b0, 1'b0}, // R2 one low
        '{20'hFFFFF, 6'd17, 40'h5555555555, 1'b1, 1'b0}, // R3 disabled
        '{20'h00000, 6'd30, 40'hAAAAAAAAAA, 1'b0, 1'b1}, // R2 all inverted
        '{20'h00400, 6'd30, 40'hAAAAAAAAAA, 1'b0, 1'b0}, // R2 one high
        '{20'h00008, 6'd40, 40'h00000000C0, 1'b0, 1'b0}, // R4 sig3 both
        '{20'h00005, 6'd8,  40'h0000000019, 1'b0, 1'b1}, // R2 mixed polarity
        '{20'h12345, 6'd9,  40'h0000000000, 1'b1, 1'b0}, // R3 empty but disabled
        '{20'h12345, 6'd9,  40'h0000000000, 1'b0, 1'b1}  // R5 empty enabled
    };

    task automatic check(input string req, input logic [ROW_N-1:0] act, input logic [ROW_N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        sig_in = '0; link_map = '0; term_kill = '0;
        #1;
        // Initial state: empty map, nothing disabled, so every row is high. R5
        check("R5 initial", term_out, {ROW_N{1'b1}});

        // Table walk: the target row takes its expected value and the other rows stay high. R2 R6
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            logic [ROW_N-1:0] e;
            v = VECS[i];
            link_map = '0;
            term_kill = '0;
            link_map[int'(v.row)*COL_N +: COL_N] = v.link;
            term_kill[v.row] = v.kill;
            sig_in = v.sig;
            #1;
            e = {ROW_N{1'b1}};
            e[v.row] = v.exp;
            check($sformatf("R2/R6 vector %0d", i), term_out, e);
        end

        // Every row disabled, with every row connected to all true columns and all inputs high. R3
        sig_in = '1; term_kill = '1;
        for (int r = 0; r < ROW_N; r++) link_map[r*COL_N +: COL_N] = 40'h5555555555;
        #1;
        check("R3 all disabled", term_out, '0);

        // A disable pattern lands in the right cell slots. R6
        link_map = '0; term_kill = 64'hF0F0_0F0F_A5A5_0001;
        #1;
        check("R6 kill pattern", term_out, ~64'hF0F0_0F0F_A5A5_0001);

        // Column walk: row k takes true sig k, row 20+k takes inverted sig k. R1
        term_kill = '0; link_map = '0;
        for (int k = 0; k < SIG_N; k++) begin
            link_map[k*COL_N + 2*k] = 1'b1;
            link_map[(SIG_N+k)*COL_N + 2*k+1] = 1'b1;
        end
        sig_in = 20'hA5C3E;
        #1;
        check("R1 true cols", {44'h0, term_out[19:0]}, {44'h0, 20'hA5C3E});
        check("R1 inverted cols", {44'h0, term_out[39:20]}, {44'h0, ~20'hA5C3E});

        // Input change seen with no clock edge in between. R7
        sig_in = ~20'hA5C3E;
        #1;
        check("R7 zero latency", {44'h0, term_out[19:0]}, {44'h0, ~20'hA5C3E});

        // Both polarities of every signal on one row: low for any input. R4
        link_map = '0;
        link_map[50*COL_N +: COL_N] = '1;
        sig_in = 20'h0F0F0;
        #1;
        check("R4 full row", {63'h0, term_out[50]}, 64'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule